// File: doc/BRIEF.md
# Dual-Strobe Up/Down Counter with Cascade Outputs

This block is a 4-bit reversible binary counter. It has no direction input. Instead it takes two count strobes that idle high. A rising edge on the up strobe adds one to the count, and a rising edge on the down strobe subtracts one. All count bits change in the same system clock cycle. A synchronous active-high clear and an active-low parallel preset override counting, so the block can serve as a modulo-N divider.

Both strobes are sampled by a fast system clock through a synchronizer chain, and their rising edges are detected in that clock domain. There are two active-low cascade outputs:
- The carry output is the terminal-count condition gated by the up strobe level.
- The borrow output is the zero condition gated by the down strobe level.

Both are combinational. To build a wider counter, wire one stage's carry and borrow outputs to the up and down strobes of the next stage. The next stage then steps on the trailing rising edge of each carry or borrow pulse, in the same cycle as the stage that drives it.

Top module: `dual_strobe_counter`

## Requirements
- R1: A rising edge on `up_strb` while `dn_strb` is high increments `count` by one. The count changes on the third rising system clock edge after the strobe input changes (two synchronizer stages plus the count register).
- R2: A rising edge on `dn_strb` while `up_strb` is high decrements `count` by one, with the same latency as R1.
- R3: A rising edge on either strobe while the other strobe is low leaves `count` unchanged.
- R4: While `clr` is high, `count` is 0 from the next system clock edge on. This holds whatever the values of `preset_n`, `din` and both strobes.
- R5: While `preset_n` is low and `clr` is low, `count` takes the value of `din` at each system clock edge.
- R6: `carry_n` is 0 exactly while `count` is 15 and `up_strb` is 0. Otherwise it is 1.
- R7: `borrow_n` is 0 exactly while `count` is 0 and `dn_strb` is 0. Otherwise it is 1.
- R8: Counting wraps: up from 15 gives 0, and down from 0 gives 15.
- R9: If rising edges of both strobes are detected in the same system cycle, `count` is left unchanged.
- R10: A strobe edge detected while `clr` is high or `preset_n` is low is discarded. After release, `count` keeps the cleared or preset value.
- R11: Two stages chained as an 8-bit counter count correctly across the 0x0F/0x10 and 0x00/0xFF boundaries. In the chain, the upper stage's up strobe is the lower `carry_n` and its down strobe is the lower `borrow_n`.
- R12: During and just after `rst`, `count` is 0 and the synchronized strobe state is idle high, so releasing reset does not produce a count step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Active-high clear of the count |
| preset_n | input | 1 | Active-low parallel preset enable |
| din | input | WIDTH | Parallel preset value |
| up_strb | input | 1 | Up count strobe, idle high, acts on its rising edge |
| dn_strb | input | 1 | Down count strobe, idle high, acts on its rising edge |
| count | output | WIDTH | Current count |
| carry_n | output | 1 | Active-low carry: count all ones and up strobe low |
| borrow_n | output | 1 | Active-low borrow: count zero and down strobe low |

## Verification
A wrong synchronizer or edge-detector state appears at `count` as a missing, doubled or misdirected step. It shows up three system clocks after the strobe moves, so every check samples a few cycles after each strobe edge. A wrong count register shows at once on `carry_n` and `borrow_n` whenever the matching strobe is low. In a chain, an error in the lower stage shows in the upper stage's count one strobe pulse later, at the nibble boundaries.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_INC  = 2'd1,
    ACT_DEC  = 2'd2
  } act_e;
endpackage

// File: rtl/dsc_strobe_sync.sv
// Synchronizer chain plus rising-edge detector for one idle-high strobe.
module dsc_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic strb_in,
  output logic lvl,
  output logic rise
);
  logic [STAGES-1:0] sr;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) sr[0] <= 1'b1;
    else     sr[0] <= strb_in;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) sr[i] <= 1'b1;
      else     sr[i] <= sr[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b1;
    else     prev <= sr[STAGES-1];
  end

  assign lvl  = sr[STAGES-1];
  assign rise = sr[STAGES-1] & ~prev;
endmodule

// File: rtl/dsc_count_core.sv
// Count register: clear beats preset, preset beats counting.
module dsc_count_core
  import dsc_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             preset_n,
  input  logic [WIDTH-1:0] din,
  input  logic             up_lvl,
  input  logic             up_rise,
  input  logic             dn_lvl,
  input  logic             dn_rise,
  output logic [WIDTH-1:0] q
);
  act_e act;

  // A step needs the idle strobe high; simultaneous edges cancel.
  always_comb begin
    act = ACT_HOLD;
    if (up_rise && dn_lvl && !dn_rise)      act = ACT_INC;
    else if (dn_rise && up_lvl && !up_rise) act = ACT_DEC;
  end

  always_ff @(posedge clk) begin
    if (rst || clr)     q <= '0;
    else if (!preset_n) q <= din;
    else begin
      unique case (act)
        ACT_INC: q <= q + 1'b1;
        ACT_DEC: q <= q - 1'b1;
        default: q <= q;
      endcase
    end
  end
endmodule

// File: rtl/dsc_cascade.sv
// Combinational active-low cascade pulses gated by the raw strobe levels.
module dsc_cascade #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] q,
  input  logic             up_strb,
  input  logic             dn_strb,
  output logic             carry_n,
  output logic             borrow_n
);
  localparam logic [WIDTH-1:0] TOP = '1;
  assign carry_n  = ~((q == TOP) & ~up_strb);
  assign borrow_n = ~((q == '0)  & ~dn_strb);
endmodule

// File: rtl/dual_strobe_counter.sv
module dual_strobe_counter #(
  parameter int WIDTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             preset_n,
  input  logic [WIDTH-1:0] din,
  input  logic             up_strb,
  input  logic             dn_strb,
  output logic [WIDTH-1:0] count,
  output logic             carry_n,
  output logic             borrow_n
);
  logic up_lvl, up_rise, dn_lvl, dn_rise;

  dsc_strobe_sync #(.STAGES(SYNC_STAGES)) u_up_sync (
    .clk(clk), .rst(rst), .strb_in(up_strb), .lvl(up_lvl), .rise(up_rise)
  );

  dsc_strobe_sync #(.STAGES(SYNC_STAGES)) u_dn_sync (
    .clk(clk), .rst(rst), .strb_in(dn_strb), .lvl(dn_lvl), .rise(dn_rise)
  );

  dsc_count_core #(.WIDTH(WIDTH)) u_core (
    .clk(clk), .rst(rst), .clr(clr), .preset_n(preset_n), .din(din),
    .up_lvl(up_lvl), .up_rise(up_rise), .dn_lvl(dn_lvl), .dn_rise(dn_rise),
    .q(count)
  );

  dsc_cascade #(.WIDTH(WIDTH)) u_casc (
    .q(count), .up_strb(up_strb), .dn_strb(dn_strb),
    .carry_n(carry_n), .borrow_n(borrow_n)
  );
endmodule

// File: rtl/dsc_checker.sv
module dsc_checker #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             clr,
  input logic             preset_n,
  input logic [WIDTH-1:0] din,
  input logic             up_strb,
  input logic             dn_strb,
  input logic [WIDTH-1:0] count,
  input logic             carry_n,
  input logic             borrow_n,
  input logic             up_lvl,
  input logic             up_rise,
  input logic             dn_lvl,
  input logic             dn_rise
);
  localparam logic [WIDTH-1:0] TOP = '1;

  // R1
  up_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && preset_n && up_rise && dn_lvl && !dn_rise) |=> count == $past(count) + 1'b1);

  // R2
  dn_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && preset_n && dn_rise && up_lvl && !up_rise) |=> count == $past(count) - 1'b1);

  // R3
  blocked_up_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && preset_n && up_rise && !dn_lvl && !dn_rise) |=> $stable(count));

  // R4
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> count == '0);

  // R5
  preset_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && !preset_n) |=> count == $past(din));

  // R6
  carry_low_chk: assert property (@(posedge clk) disable iff (rst)
    (count == TOP && !up_strb) |-> !carry_n);

  // R6
  carry_high_chk: assert property (@(posedge clk) disable iff (rst)
    (count != TOP || up_strb) |-> carry_n);

  // R7
  borrow_chk: assert property (@(posedge clk) disable iff (rst)
    borrow_n == !(count == '0 && !dn_strb));

  // R9
  both_edges_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && preset_n && up_rise && dn_rise) |=> $stable(count));
endmodule

bind dual_strobe_counter dsc_checker #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .clr(clr), .preset_n(preset_n), .din(din),
  .up_strb(up_strb), .dn_strb(dn_strb), .count(count),
  .carry_n(carry_n), .borrow_n(borrow_n),
  .up_lvl(up_lvl), .up_rise(up_rise), .dn_lvl(dn_lvl), .dn_rise(dn_rise)
);

// File: tb/dual_strobe_counter_test.sv
module dual_strobe_counter_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       clr = 1'b0;
  logic       preset_n = 1'b1;
  logic [3:0] din = 4'd0;
  logic       up = 1'b1;
  logic       dn = 1'b1;
  logic [3:0] count;
  logic       carry_n, borrow_n;

  // chained pair
  logic       c_clr = 1'b0;
  logic       c_preset_n = 1'b1;
  logic [7:0] c_din = 8'd0;
  logic       c_up = 1'b1;
  logic       c_dn = 1'b1;
  logic [3:0] lo_q, hi_q;
  logic       lo_carry, lo_borrow, hi_carry, hi_borrow;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  dual_strobe_counter uut (
    .clk(clk), .rst(rst), .clr(clr), .preset_n(preset_n), .din(din),
    .up_strb(up), .dn_strb(dn), .count(count), .carry_n(carry_n), .borrow_n(borrow_n)
  );

  dual_strobe_counter u_lo (
    .clk(clk), .rst(rst), .clr(c_clr), .preset_n(c_preset_n), .din(c_din[3:0]),
    .up_strb(c_up), .dn_strb(c_dn), .count(lo_q), .carry_n(lo_carry), .borrow_n(lo_borrow)
  );

  dual_strobe_counter u_hi (
    .clk(clk), .rst(rst), .clr(c_clr), .preset_n(c_preset_n), .din(c_din[7:4]),
    .up_strb(lo_carry), .dn_strb(lo_borrow), .count(hi_q), .carry_n(hi_carry), .borrow_n(hi_borrow)
  );

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_preset(input logic [3:0] v);
    @(negedge clk); preset_n = 1'b0; din = v;
    @(negedge clk); preset_n = 1'b1;
  endtask

  task automatic t_reset;
    settle(2);
    chk("R12 count in reset", count, 0);
    chk("R12 carry in reset", carry_n, 1);
    chk("R12 borrow in reset", borrow_n, 1);
    @(negedge clk); rst = 1'b0;
    settle(6);
    chk("R12 no step after reset", count, 0);
  endtask

  task automatic t_sequence;
    int exp;
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    chk("R4 clear", count, 0);
    do_preset(4'd13);
    chk("R5 preset 13", count, 13);
    exp = 13;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); up = 1'b0; settle(4);
      chk("R6 carry while up low", carry_n, (exp == 15) ? 0 : 1);
      up = 1'b1; settle(5);
      exp = (exp + 1) % 16;
      chk("R1 R8 up step", count, exp);
      chk("R6 carry idle", carry_n, 1);
    end
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); dn = 1'b0; settle(4);
      chk("R7 borrow while down low", borrow_n, (exp == 0) ? 0 : 1);
      dn = 1'b1; settle(5);
      exp = (exp + 15) % 16;
      chk("R2 R8 down step", count, exp);
      chk("R7 borrow idle", borrow_n, 1);
    end
    chk("R8 sequence end", count, 13);
  endtask

  task automatic t_blocked;
    do_preset(4'd6);
    @(negedge clk); dn = 1'b0; settle(4);
    up = 1'b0; settle(4);
    up = 1'b1; settle(6);
    chk("R3 up edge with down low", count, 6);
    dn = 1'b1; settle(6);
    chk("R2 down edge after block", count, 5);
    @(negedge clk); up = 1'b0; settle(4);
    dn = 1'b0; settle(4);
    dn = 1'b1; settle(6);
    chk("R3 down edge with up low", count, 5);
    up = 1'b1; settle(6);
    chk("R1 up edge after block", count, 6);
  endtask

  task automatic t_both;
    do_preset(4'd9);
    @(negedge clk); up = 1'b0; dn = 1'b0; settle(5);
    up = 1'b1; dn = 1'b1; settle(6);
    chk("R9 simultaneous edges", count, 9);
  endtask

  task automatic t_preset_follow;
    @(negedge clk); preset_n = 1'b0; din = 4'd5;
    @(negedge clk); chk("R5 follow 5", count, 5);
    din = 4'd10;
    @(negedge clk); chk("R5 follow 10", count, 10);
    up = 1'b0; settle(4);
    up = 1'b1; settle(6);
    chk("R10 edge during preset", count, 10);
    preset_n = 1'b1; settle(6);
    chk("R10 after preset release", count, 10);
  endtask

  task automatic t_clear_priority;
    @(negedge clk); preset_n = 1'b0; din = 4'd7; clr = 1'b1;
    @(negedge clk); chk("R4 clear over preset", count, 0);
    preset_n = 1'b1; dn = 1'b0; settle(4);
    dn = 1'b1; settle(6);
    chk("R4 clear over strobe", count, 0);
    clr = 1'b0; settle(6);
    chk("R10 after clear release", count, 0);
  endtask

  task automatic chain_pulse(input bit go_up, input int exp, input string tag);
    @(negedge clk);
    if (go_up) c_up = 1'b0; else c_dn = 1'b0;
    settle(5);
    if (go_up) c_up = 1'b1; else c_dn = 1'b1;
    settle(8);
    chk(tag, {hi_q, lo_q}, exp);
  endtask

  task automatic t_chain;
    @(negedge clk); c_preset_n = 1'b0; c_din = 8'h0E;
    @(negedge clk); c_preset_n = 1'b1;
    chk("R11 chain preset", {hi_q, lo_q}, 8'h0E);
    chain_pulse(1'b1, 8'h0F, "R11 up to 0x0F");
    @(negedge clk); c_up = 1'b0; settle(4);
    chk("R11 low carry pulse", lo_carry, 0);
    c_up = 1'b1; settle(8);
    chk("R11 ripple to 0x10", {hi_q, lo_q}, 8'h10);
    chain_pulse(1'b1, 8'h11, "R11 up to 0x11");
    chain_pulse(1'b0, 8'h10, "R11 down to 0x10");
    chain_pulse(1'b0, 8'h0F, "R11 borrow to 0x0F");
    @(negedge clk); c_preset_n = 1'b0; c_din = 8'h00;
    @(negedge clk); c_preset_n = 1'b1;
    chain_pulse(1'b0, 8'hFF, "R11 wrap to 0xFF");
    chain_pulse(1'b1, 8'h00, "R11 wrap to 0x00");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_sequence();
    t_blocked();
    t_both();
    t_preset_follow();
    t_clear_priority();
    t_chain();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule